// File: doc/BRIEF.md
# Admin Command Queue Doorbell Engine

This block is the device side of an administrative command queue that lives in host memory. The host gives the page frame of the queue, places fixed-size commands in consecutive slots of that page, and then rings a doorbell by writing its running total of submitted commands. The engine walks from its own count of finished commands up to that total. For each command it reads the opcode word of the slot through a simple request/acknowledge memory port, runs a stub executor on it, and writes a status word back into the same slot. Only once that status write has been acknowledged does it advance the event counter that the host polls.

Both counts run freely and wrap at 32 bits. The slot used for a command is its count modulo the number of slots in the page. All register values and all memory words cross the bus in big-endian byte order. Writing a zero page frame is a full device reset: the queue is released, both counters return to zero, and any memory request in flight is dropped.

Top module: `cmdq_doorbell_eng`

## Requirements
- R1: After `rst_n` is released, all four registers read zero and `mem_req` is low.
- R2: Registers sit at byte offsets 0x0 (page frame, low 20 bits kept), 0x4 (doorbell), 0x8 (event counter, read-only) and 0xC (status, read-only), selected by `mmio_addr[3:2]`. Every value on `mmio_wdata` and `mmio_rdata` is the big-endian form of the register value: byte 0 of the register is placed in bits 31:24.
- R3: When the page frame is nonzero and the doorbell differs from the event counter, the engine reads the opcode word at byte address `(page_frame << 12) + slot*64`.
- R4: The status written back is 1 for a nonzero opcode and 2 for opcode zero. It is written to byte offset 4 of the same slot, and both words are big-endian in memory.
- R5: The event counter rises by exactly one per command, and only in the cycle after the acknowledge of that command's status write. When the engine is idle again, the event counter equals the doorbell.
- R6: The slot is the event count modulo 64 (4096-byte page, 64-byte slots), so command 64 reuses slot 0. Both counters are 32 bits wide and wrap to zero.
- R7: A doorbell write made while commands are running raises the target. Every command up to the new value is executed, each exactly once.
- R8: Writing page frame 0 clears the page frame, doorbell and event counter, and drops `mem_req` by the next cycle, abandoning any access in flight.
- R9: A doorbell write made while the page frame is zero is ignored: the doorbell still reads 0 and no memory request is issued.
- R10: Status register bit 0 is 1 when the page frame is nonzero. Bit 1 is 1 while the event counter differs from the doorbell. All other bits read 0.
- R11: Once raised, `mem_req` stays high with a stable address and direction until `mem_ack`, unless a reset is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mmio_we | input | 1 | Register write strobe |
| mmio_addr | input | 4 | Register byte offset |
| mmio_wdata | input | 32 | Register write data, big-endian |
| mmio_rdata | output | 32 | Register read data, big-endian, combinational |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data, big-endian |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Access complete |

## Verification
The assertions check on every cycle that:
- the event counter moves only by one and only after an acknowledged status write;
- a request holds its address until acknowledged;
- no request exists without a page frame;
- a processing run starts only when there is outstanding work;
- a zero page-frame write clears the counters and the request.

Only the bench's scenarios can show the rest:
- the exact slot addresses, including the reuse of slot 0 after 64 commands;
- that the status value matches the opcode that was read;
- that a doorbell raised mid-run completes every new command exactly once;
- that a doorbell written with no page frame leaves no trace.

// File: rtl/cmdq_pkg.sv
package cmdq_pkg;
  localparam int DATA_W = 32;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_FETCH = 2'd1,
    SQ_STORE = 2'd2
  } seq_state_t;

  localparam logic [1:0] REG_PFN      = 2'd0;
  localparam logic [1:0] REG_DOORBELL = 2'd1;
  localparam logic [1:0] REG_EVENT    = 2'd2;
  localparam logic [1:0] REG_STATUS   = 2'd3;

  localparam logic [DATA_W-1:0] CMD_OK         = 32'd1;
  localparam logic [DATA_W-1:0] CMD_BAD_OPCODE = 32'd2;

  // big-endian bus word <-> internal value
  function automatic logic [DATA_W-1:0] bswap32(input logic [DATA_W-1:0] v);
    return {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  // stub executor: any nonzero opcode succeeds
  function automatic logic [DATA_W-1:0] exec_status(input logic [DATA_W-1:0] opc);
    return (opc == '0) ? CMD_BAD_OPCODE : CMD_OK;
  endfunction
endpackage

// File: rtl/cmdq_regs.sv
module cmdq_regs
  import cmdq_pkg::*;
#(
  parameter int PFN_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmio_we,
  input  logic [3:0]        mmio_addr,
  input  logic [DATA_W-1:0] mmio_wdata,
  input  logic [DATA_W-1:0] ev_cnt,
  input  logic              busy,
  output logic [PFN_W-1:0]  pfn,
  output logic [DATA_W-1:0] db_cnt,
  output logic              soft_rst,
  output logic [DATA_W-1:0] mmio_rdata
);
  logic [1:0]        sel;
  logic [DATA_W-1:0] wval;
  logic [PFN_W-1:0]  pfn_next;
  logic              pfn_wr;
  logic              db_wr;
  logic [DATA_W-1:0] rval;

  assign sel      = mmio_addr[3:2];
  assign wval     = bswap32(mmio_wdata);
  assign pfn_next = wval[PFN_W-1:0];
  assign pfn_wr   = mmio_we && (sel == REG_PFN);
  assign soft_rst = pfn_wr && (pfn_next == '0);
  assign db_wr    = mmio_we && (sel == REG_DOORBELL) && (pfn != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pfn    <= '0;
      db_cnt <= '0;
    end else begin
      if (pfn_wr) pfn <= pfn_next;
      if (soft_rst)   db_cnt <= '0;
      else if (db_wr) db_cnt <= wval;
    end
  end

  always_comb begin
    case (sel)
      REG_PFN:      rval = DATA_W'(pfn);
      REG_DOORBELL: rval = db_cnt;
      REG_EVENT:    rval = ev_cnt;
      default:      rval = {{(DATA_W-2){1'b0}}, busy, (pfn != '0)};
    endcase
  end

  assign mmio_rdata = bswap32(rval);
endmodule

// File: rtl/cmdq_exec.sv
module cmdq_exec
  import cmdq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [DATA_W-1:0] opcode_be,
  output logic [DATA_W-1:0] status_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  status_q <= '0;
    else if (go) status_q <= exec_status(bswap32(opcode_be));
  end
endmodule

// File: rtl/cmdq_seq.sv
module cmdq_seq
  import cmdq_pkg::*;
#(
  parameter int PFN_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int SLOT_SHIFT = 6,
  parameter int STATUS_OFS = 4,
  localparam int ADDR_W     = PFN_W + PAGE_SHIFT,
  localparam int SLOT_IDX_W = PAGE_SHIFT - SLOT_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              soft_rst,
  input  logic [PFN_W-1:0]  pfn,
  input  logic [DATA_W-1:0] db_cnt,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] status_q,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] ev_cnt,
  output logic              busy,
  output logic              fetch_done,
  output logic              cmd_done
);
  seq_state_t        state;
  logic [DATA_W-1:0] ev_inc;
  logic              has_work;

  function automatic logic [ADDR_W-1:0] slot_addr(input logic [PFN_W-1:0] frame,
                                                  input logic [DATA_W-1:0] cnt,
                                                  input logic [SLOT_SHIFT-1:0] ofs);
    return {frame, cnt[SLOT_IDX_W-1:0], ofs};
  endfunction

  assign ev_inc     = ev_cnt + 1'b1;
  assign busy       = (ev_cnt != db_cnt);
  assign has_work   = (pfn != '0) && busy;
  assign fetch_done = (state == SQ_FETCH) && mem_ack;
  assign cmd_done   = (state == SQ_STORE) && mem_ack;

  always_ff @(posedge clk) begin
    if (!rst_n || soft_rst) begin
      state  <= SQ_IDLE;
      ev_cnt <= '0;
    end else begin
      case (state)
        SQ_IDLE:  if (has_work) state <= SQ_FETCH;
        SQ_FETCH: if (mem_ack)  state <= SQ_STORE;
        SQ_STORE: if (mem_ack) begin
          ev_cnt <= ev_inc;
          state  <= (ev_inc != db_cnt) ? SQ_FETCH : SQ_IDLE;
        end
        default:  state <= SQ_IDLE;
      endcase
    end
  end

  assign mem_req   = (state != SQ_IDLE);
  assign mem_we    = (state == SQ_STORE);
  assign mem_addr  = slot_addr(pfn, ev_cnt,
                               mem_we ? SLOT_SHIFT'(STATUS_OFS) : '0);
  assign mem_wdata = bswap32(status_q);
endmodule

// File: rtl/cmdq_doorbell_eng.sv
module cmdq_doorbell_eng
  import cmdq_pkg::*;
#(
  parameter int PFN_W      = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int SLOT_SHIFT = 6,
  parameter int STATUS_OFS = 4,
  localparam int ADDR_W    = PFN_W + PAGE_SHIFT
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mmio_we,
  input  logic [3:0]        mmio_addr,
  input  logic [31:0]       mmio_wdata,
  output logic [31:0]       mmio_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack
);
  logic [PFN_W-1:0]  pfn;
  logic [DATA_W-1:0] db_cnt;
  logic [DATA_W-1:0] ev_cnt;
  logic [DATA_W-1:0] status_q;
  logic              soft_rst;
  logic              busy;
  logic              fetch_done;
  logic              cmd_done;
  logic              pfn_zero;

  assign pfn_zero = (pfn == '0);

  cmdq_regs #(.PFN_W(PFN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .mmio_we(mmio_we), .mmio_addr(mmio_addr),
    .mmio_wdata(mmio_wdata), .ev_cnt(ev_cnt), .busy(busy), .pfn(pfn),
    .db_cnt(db_cnt), .soft_rst(soft_rst), .mmio_rdata(mmio_rdata)
  );

  cmdq_exec u_exec (
    .clk(clk), .rst_n(rst_n), .go(fetch_done), .opcode_be(mem_rdata),
    .status_q(status_q)
  );

  cmdq_seq #(
    .PFN_W(PFN_W), .PAGE_SHIFT(PAGE_SHIFT), .SLOT_SHIFT(SLOT_SHIFT),
    .STATUS_OFS(STATUS_OFS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pfn(pfn), .db_cnt(db_cnt),
    .mem_ack(mem_ack), .status_q(status_q), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .ev_cnt(ev_cnt), .busy(busy),
    .fetch_done(fetch_done), .cmd_done(cmd_done)
  );
endmodule

// File: rtl/cmdq_chk.sv
module cmdq_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              soft_rst,
  input logic              pfn_zero,
  input logic [31:0]       db_cnt,
  input logic [31:0]       ev_cnt,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr
);
  AST_EV_ONLY_AFTER_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cnt != $past(ev_cnt)) && !$past(soft_rst) |-> $past(mem_req && mem_we && mem_ack)); // R5
  AST_EV_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_cnt != $past(ev_cnt)) && !$past(soft_rst) |-> ev_cnt == $past(ev_cnt) + 32'd1); // R6
  AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (ev_cnt == 32'd0) && (db_cnt == 32'd0) && !mem_req); // R8
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack && !soft_rst |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11
  AST_NO_REQ_WITHOUT_QUEUE: assert property (@(posedge clk) disable iff (!rst_n)
    pfn_zero |-> !mem_req); // R9
  AST_START_NEEDS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req) |-> $past(!pfn_zero && (db_cnt != ev_cnt))); // R3
endmodule

bind cmdq_doorbell_eng cmdq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .pfn_zero(pfn_zero),
  .db_cnt(db_cnt), .ev_cnt(ev_cnt), .mem_req(mem_req), .mem_we(mem_we),
  .mem_ack(mem_ack), .mem_addr(mem_addr)
);

// File: tb/tb_cmdq_doorbell_eng.sv
module tb_cmdq_doorbell_eng;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mmio_we = 1'b0;
  logic [3:0]  mmio_addr = 4'h0;
  logic [31:0] mmio_wdata = 32'h0;
  logic [31:0] mmio_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [31:0] mem_rdata = 32'h0;
  logic        mem_ack = 1'b0;

  always #5 clk = ~clk;

  cmdq_doorbell_eng dut (
    .clk(clk), .rst_n(rst_n), .mmio_we(mmio_we), .mmio_addr(mmio_addr),
    .mmio_wdata(mmio_wdata), .mmio_rdata(mmio_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  int checks = 0;
  int errors = 0;

  localparam int NVEC = 5;
  localparam logic [31:0] VEC_DB [NVEC] = '{32'd1, 32'd3, 32'd8, 32'd8, 32'd70};

  logic [31:0] mem [0:1023];
  logic [19:0] bench_pfn = 20'h0;
  int          done_cnt = 0;
  int          lat = 0;
  logic [31:0] start_addr = 32'h0;
  bit          req_seen = 1'b0;

  function automatic logic [31:0] be(input logic [31:0] v);
    be = {v[7:0], v[15:8], v[23:16], v[31:24]};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic mmio_write(input logic [1:0] sel, input logic [31:0] val);
    @(negedge clk);
    mmio_we = 1'b1; mmio_addr = {sel, 2'b00}; mmio_wdata = be(val);
    @(negedge clk);
    mmio_we = 1'b0;
  endtask

  task automatic mmio_read(input logic [1:0] sel, output logic [31:0] val);
    @(negedge clk);
    mmio_addr = {sel, 2'b00};
    #1 val = be(mmio_rdata);
  endtask

  task automatic wait_ev(input logic [31:0] target, input string tag);
    logic [31:0] v = 32'h0;
    for (int i = 0; i < 4000; i++) begin
      mmio_read(2'd2, v);
      if (v == target) break;
    end
    chk(v == target, tag, v, target);
  endtask

  // memory model: ack after two wait cycles, checks every access
  always @(negedge clk) begin
    if (req_seen == 1'b0 && mem_req) req_seen = 1'b1;
    if (mem_ack) begin
      mem_ack = 1'b0; lat = 0;
    end else if (mem_req) begin
      if (lat == 0) start_addr = mem_addr;
      if (lat == 2) begin
        logic [31:0] exp_a;
        int slot;
        slot  = done_cnt % 64;
        exp_a = {bench_pfn, 12'h000} + 32'(slot * 64) + (mem_we ? 32'd4 : 32'd0);
        chk(mem_addr == exp_a, mem_we ? "R4 status address" : "R3/R6 fetch address", mem_addr, exp_a);
        chk(mem_addr == start_addr, "R11 address held", mem_addr, start_addr);
        if (mem_we) begin
          logic [31:0] exp_s;
          exp_s = (be(mem[slot*16]) == 32'h0) ? 32'd2 : 32'd1;
          chk(be(mem_wdata) == exp_s, "R4 status value", be(mem_wdata), exp_s);
          mem[mem_addr[11:2]] = mem_wdata;
          done_cnt++;
        end else begin
          mem_rdata = mem[mem_addr[11:2]];
        end
        mem_ack = 1'b1;
      end else lat++;
    end else lat = 0;
  end

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] v;
    for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
    for (int k = 0; k < 64; k++) mem[k*16] = be((k % 3 == 0) ? 32'h0 : 32'h100 + k);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int s = 0; s < 4; s++) begin
      mmio_read(2'(s), v);
      chk(v == 32'h0, "R1 register reset", v, 32'h0);
    end
    chk(mem_req == 1'b0, "R1 no request", {31'h0, mem_req}, 32'h0);

    // R9 doorbell ignored without page frame
    req_seen = 1'b0;
    mmio_write(2'd1, 32'd5);
    repeat (20) @(negedge clk);
    mmio_read(2'd1, v);
    chk(v == 32'h0, "R9 doorbell ignored", v, 32'h0);
    chk(req_seen == 1'b0, "R9 no memory request", {31'h0, req_seen}, 32'h0);

    // R2 page frame register, raw big-endian bus form
    bench_pfn = 20'h00123;
    mmio_write(2'd0, 32'h0000_0123);
    @(negedge clk); mmio_addr = 4'h0; #1;
    chk(mmio_rdata == 32'h2301_0000, "R2 big-endian readback", mmio_rdata, 32'h2301_0000);
    mmio_read(2'd3, v);
    chk(v == 32'h1, "R10 status enabled idle", v, 32'h1);

    // table-driven doorbell runs
    for (int i = 0; i < NVEC; i++) begin
      mmio_write(2'd1, VEC_DB[i]);
      wait_ev(VEC_DB[i], "R5 event counter reaches doorbell");
      chk(done_cnt == int'(VEC_DB[i]), "R5 one status per command", 32'(done_cnt), VEC_DB[i]);
      mmio_read(2'd3, v);
      chk(v == 32'h1, "R10 status idle after run", v, 32'h1);
    end
    // R6: commands 64..69 reused slots 0..5 (addresses checked by model)
    chk(be(mem[3*16+1]) == 32'd2, "R4 status word in slot 3", be(mem[3*16+1]), 32'd2);
    chk(be(mem[4*16+1]) == 32'd1, "R4 status word in slot 4", be(mem[4*16+1]), 32'd1);

    // R7 doorbell raised while busy
    mmio_write(2'd1, 32'd72);
    mmio_write(2'd1, 32'd75);
    wait_ev(32'd75, "R7 raised target reached");
    chk(done_cnt == 75, "R7 each command once", 32'(done_cnt), 32'd75);

    // R10 busy bit
    mmio_write(2'd1, 32'd80);
    mmio_read(2'd3, v);
    chk(v == 32'h3, "R10 status busy", v, 32'h3);
    wait_ev(32'd80, "R5 run to 80");

    // R8 reset with access in flight
    mmio_write(2'd1, 32'd85);
    for (int i = 0; i < 50; i++) begin
      @(negedge clk);
      if (mem_req && lat == 1) break;
    end
    mmio_write(2'd0, 32'h0);
    chk(mem_req == 1'b0, "R8 request dropped", {31'h0, mem_req}, 32'h0);
    done_cnt = 0;
    for (int s = 0; s < 3; s++) begin
      mmio_read(2'(s), v);
      chk(v == 32'h0, "R8 registers cleared", v, 32'h0);
    end

    // re-enable on a new page
    bench_pfn = 20'h00456;
    mmio_write(2'd0, 32'h0000_0456);
    mmio_write(2'd1, 32'd2);
    wait_ev(32'd2, "R3 restart on new page");
    chk(done_cnt == 2, "R3 commands after restart", 32'(done_cnt), 32'd2);

    finish_run();
  end
endmodule